// File: doc/BRIEF.md
# Banked Dual Page-Size Translation Buffer

This block translates virtual addresses to physical addresses using two cooperating translation stores. One store keeps 64 KB page translations. The other keeps 4 KB page translations. The CPU never supplies a small-page translation directly. A small-page translation enters the small store only when a large-page entry is evicted. At that moment, the 4 KB sub-page that the evicted entry used most recently is kept. Two page sizes are therefore handled entirely in hardware, with no operating-system help.

Each store is split into banks, and every bank is fully associative. A lookup compares only the bank picked by a few address bits in each store. This reduces the number of entries compared at once. Both selected banks are searched in the same cycle. A miss in both stores raises a request to an outside page walker, which answers with a 64 KB translation.

Each entry carries one recency bit. Replacement is decided from the valid and recency bits only.

Top module: `dual_page_tlb`

## Requirements
- R1: After reset or a flush, every entry in both stores is invalid, `resp_valid` and `refill_req` are 0, and the next lookup of any address misses.
- R2: A lookup accepted at a clock edge gives `resp_valid`=1 after that edge for exactly one cycle. On a small-store hit, `resp_pa` is {small physical page, VA[11:0]}. On a large-store hit, `resp_pa` is {large physical page, VA[15:0]}.
- R3: On a miss in both stores, the response has `resp_hit`=0 and `resp_pa`=0. `refill_req` rises in the same cycle as that response, with `refill_vpn`=VA[31:16]. It stays high until a cycle in which `refill_valid` is 1, and it is low after that edge.
- R4: While `refill_req` is high, lookup requests are ignored and produce no response.
- R5: A refill is written into large bank `refill_vpn[1:0]` (that is, VA[17:16]). Afterwards, every address inside that 64 KB page hits with physical page `refill_ppn`.
- R6: Each large entry records the 4 KB sub-page index VA[15:12] of its most recent reference. The refill sets it to the missed address's index, and every large hit updates it. When a valid large entry is evicted, the translation of that one sub-page is written into small bank VA[12] of that sub-page. The other sub-pages of the evicted page then miss.
- R7: If both stores hit on the same lookup, the small-store translation is returned.
- R8: A reference (a hit or a fill) sets the entry's recency bit. If that would leave all 8 bits of the bank set, the other 7 are cleared. The victim is the lowest-indexed invalid entry, or else the lowest-indexed entry whose recency bit is clear.
- R9: `flush` has priority over a lookup and a refill in the same cycle. It cancels a pending `refill_req` and gives no response in the next cycle.
- R10: A fill affects only the bank it selects. Entries in other large banks stay valid and keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries and cancel a pending refill |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Lookup result is present this cycle |
| resp_hit | output | 1 | Result is a hit |
| resp_pa | output | 32 | Translated physical address (0 on a miss) |
| refill_req | output | 1 | Request for a 64 KB translation from the walker |
| refill_vpn | output | 16 | 64 KB virtual page number being requested |
| refill_valid | input | 1 | Walker supplies the translation this cycle |
| refill_ppn | input | 16 | 64 KB physical page number from the walker |

## Verification
A lookup driven on a falling edge is captured at the next rising edge. Its hit flag and address are due on the falling edge after that, one cycle later. The monitor compares the queued expectation there. On a miss, `refill_req` and `refill_vpn` are due at that same falling edge. After `refill_valid` is held across one rising edge, `refill_req` must be low at the following falling edge. Flushes and requests made while a refill is pending are checked by confirming that nothing appears at the falling edge one cycle later.

// File: rtl/dual_page_tlb.sv
module dual_page_tlb #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 16,
  parameter int WAYS        = 8,
  parameter int S_BANKS     = 2,
  parameter int L_BANKS     = 4
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        req_valid,
  input  logic [VA_W-1:0]             req_va,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [PA_W-1:0]             resp_pa,
  output logic                        refill_req,
  output logic [VA_W-LARGE_SHIFT-1:0] refill_vpn,
  input  logic                        refill_valid,
  input  logic [PA_W-LARGE_SHIFT-1:0] refill_ppn
);
  localparam int LV_W  = VA_W - LARGE_SHIFT;
  localparam int LP_W  = PA_W - LARGE_SHIFT;
  localparam int SV_W  = VA_W - SMALL_SHIFT;
  localparam int SP_W  = PA_W - SMALL_SHIFT;
  localparam int SUB_W = LARGE_SHIFT - SMALL_SHIFT;
  localparam int IDX_W = $clog2(WAYS);
  localparam int SB_W  = $clog2(S_BANKS);
  localparam int LB_W  = $clog2(L_BANKS);

  logic [WAYS-1:0]  l_val [L_BANKS];
  logic [WAYS-1:0]  l_rec [L_BANKS];
  logic [LV_W-1:0]  l_tag [L_BANKS][WAYS];
  logic [LP_W-1:0]  l_ppn [L_BANKS][WAYS];
  logic [SUB_W-1:0] l_sub [L_BANKS][WAYS];
  logic [WAYS-1:0]  s_val [S_BANKS];
  logic [WAYS-1:0]  s_rec [S_BANKS];
  logic [SV_W-1:0]  s_tag [S_BANKS][WAYS];
  logic [SP_W-1:0]  s_ppn [S_BANKS][WAYS];
  logic [SUB_W-1:0] pend_sub;

  function automatic logic [IDX_W-1:0] pick(input logic [WAYS-1:0] v, input logic [WAYS-1:0] r);
    logic [IDX_W-1:0] k;
    k = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (!r[i]) k = IDX_W'(i);
    for (int i = WAYS - 1; i >= 0; i--) if (!v[i]) k = IDX_W'(i);
    return k;
  endfunction

  function automatic logic [WAYS-1:0] touch(input logic [WAYS-1:0] r, input logic [IDX_W-1:0] i);
    logic [WAYS-1:0] one, n;
    one = '0;
    one[i] = 1'b1;
    n = r | one;
    if (&n) n = one;
    return n;
  endfunction

  wire [LB_W-1:0]  lb       = req_va[LARGE_SHIFT +: LB_W];
  wire [SB_W-1:0]  sb       = req_va[SMALL_SHIFT +: SB_W];
  wire [LV_W-1:0]  req_lvpn = req_va[VA_W-1:LARGE_SHIFT];
  wire [SV_W-1:0]  req_svpn = req_va[VA_W-1:SMALL_SHIFT];
  wire [SUB_W-1:0] req_sub  = req_va[LARGE_SHIFT-1:SMALL_SHIFT];
  wire             accept   = req_valid && !refill_req;
  wire [LB_W-1:0]  rb       = refill_vpn[LB_W-1:0];

  logic             l_hit, s_hit, dup_hit;
  logic [IDX_W-1:0] l_idx, s_idx, dup_idx;

  always_comb begin
    l_hit = 1'b0; l_idx = '0;
    s_hit = 1'b0; s_idx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (l_val[lb][i] && l_tag[lb][i] == req_lvpn) begin l_hit = 1'b1; l_idx = IDX_W'(i); end
      if (s_val[sb][i] && s_tag[sb][i] == req_svpn) begin s_hit = 1'b1; s_idx = IDX_W'(i); end
    end
  end

  wire [IDX_W-1:0] ev_idx  = pick(l_val[rb], l_rec[rb]);
  wire             ev_live = l_val[rb][ev_idx];
  wire [SV_W-1:0]  ev_svpn = {l_tag[rb][ev_idx], l_sub[rb][ev_idx]};
  wire [SP_W-1:0]  ev_sppn = {l_ppn[rb][ev_idx], l_sub[rb][ev_idx]};
  wire [SB_W-1:0]  eb      = ev_svpn[SB_W-1:0];

  always_comb begin
    dup_hit = 1'b0; dup_idx = '0;
    for (int i = 0; i < WAYS; i++)
      if (s_val[eb][i] && s_tag[eb][i] == ev_svpn) begin dup_hit = 1'b1; dup_idx = IDX_W'(i); end
  end

  wire [IDX_W-1:0] s_slot = dup_hit ? dup_idx : pick(s_val[eb], s_rec[eb]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
      refill_req <= 1'b0;
      refill_vpn <= '0;
      pend_sub   <= '0;
      for (int b = 0; b < L_BANKS; b++) begin
        l_val[b] <= '0;
        l_rec[b] <= '0;
        for (int i = 0; i < WAYS; i++) begin
          l_tag[b][i] <= '0; l_ppn[b][i] <= '0; l_sub[b][i] <= '0;
        end
      end
      for (int b = 0; b < S_BANKS; b++) begin
        s_val[b] <= '0;
        s_rec[b] <= '0;
        for (int i = 0; i < WAYS; i++) begin
          s_tag[b][i] <= '0; s_ppn[b][i] <= '0;
        end
      end
    end else if (flush) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_pa    <= '0;
      refill_req <= 1'b0;
      for (int b = 0; b < L_BANKS; b++) begin l_val[b] <= '0; l_rec[b] <= '0; end
      for (int b = 0; b < S_BANKS; b++) begin s_val[b] <= '0; s_rec[b] <= '0; end
    end else begin
      resp_valid <= accept;
      if (accept) begin
        resp_hit <= s_hit || l_hit;
        if (s_hit)      resp_pa <= {s_ppn[sb][s_idx], req_va[SMALL_SHIFT-1:0]};
        else if (l_hit) resp_pa <= {l_ppn[lb][l_idx], req_va[LARGE_SHIFT-1:0]};
        else            resp_pa <= '0;
        if (s_hit) s_rec[sb] <= touch(s_rec[sb], s_idx);
        if (l_hit) begin
          l_rec[lb]        <= touch(l_rec[lb], l_idx);
          l_sub[lb][l_idx] <= req_sub;
        end
        if (!s_hit && !l_hit) begin
          refill_req <= 1'b1;
          refill_vpn <= req_lvpn;
          pend_sub   <= req_sub;
        end
      end
      if (refill_req && refill_valid) begin
        refill_req          <= 1'b0;
        l_val[rb][ev_idx]   <= 1'b1;
        l_tag[rb][ev_idx]   <= refill_vpn;
        l_ppn[rb][ev_idx]   <= refill_ppn;
        l_sub[rb][ev_idx]   <= pend_sub;
        l_rec[rb]           <= touch(l_rec[rb], ev_idx);
        if (ev_live) begin
          s_val[eb][s_slot] <= 1'b1;
          s_tag[eb][s_slot] <= ev_svpn;
          s_ppn[eb][s_slot] <= ev_sppn;
          s_rec[eb]         <= touch(s_rec[eb], s_slot);
        end
      end
    end
  end
endmodule

module dual_page_tlb_checker #(
  parameter int PA_W = 32
)(
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic [PA_W-1:0] resp_pa,
  input logic            refill_req,
  input logic            refill_valid
);
  assert_resp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(req_valid));
  assert_refill_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && !refill_valid && !flush |=> refill_req);
  assert_refill_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && refill_valid |=> !refill_req);
  assert_miss_raises_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> refill_req);
  assert_miss_pa_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_hit |-> resp_pa == '0);
  assert_ignored_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> !resp_valid);
  assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !resp_valid && !refill_req);
endmodule

bind dual_page_tlb dual_page_tlb_checker #(.PA_W(PA_W)) i_checker (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
  .refill_req(refill_req), .refill_valid(refill_valid)
);

// File: tb/test_dual_page_tlb.sv
module test_dual_page_tlb;
  logic        clk = 0, rst_n = 0, flush = 0, req_valid = 0, refill_valid = 0;
  logic [31:0] req_va = '0;
  logic [15:0] refill_ppn = '0;
  logic        resp_valid, resp_hit, refill_req;
  logic [31:0] resp_pa;
  logic [15:0] refill_vpn;
  int tests = 0, fails = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  dual_page_tlb i_dual_page_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_va(req_va),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pa(resp_pa),
    .refill_req(refill_req), .refill_vpn(refill_vpn),
    .refill_valid(refill_valid), .refill_ppn(refill_ppn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R4 unexpected response", {31'd0, resp_hit}, 32'd0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_hit == e[32], {t, " hit"}, {31'd0, resp_hit}, {31'd0, e[32]});
        check(resp_pa == e[31:0], {t, " pa"}, resp_pa, e[31:0]);
      end
    end
  end

  task automatic lookup(input logic [31:0] va, input bit hit, input logic [31:0] pa, input string t);
    @(negedge clk);
    req_valid = 1; req_va = va;
    exp_q.push_back({hit, pa});
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic refill(input logic [15:0] ppn);
    refill_valid = 1; refill_ppn = ppn;
    @(negedge clk);
    refill_valid = 0;
    check(refill_req == 0, "R3 refill_req drops", {31'd0, refill_req}, 32'd0);
  endtask

  task automatic miss_fill(input logic [31:0] va, input logic [15:0] ppn, input string t);
    lookup(va, 0, 32'd0, t);
    check(refill_req == 1, "R3 refill_req raised", {31'd0, refill_req}, 32'd1);
    check(refill_vpn == va[31:16], "R3 refill_vpn", {16'd0, refill_vpn}, {16'd0, va[31:16]});
    refill(ppn);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(resp_valid == 0, "R1 reset resp_valid", {31'd0, resp_valid}, 32'd0);
    check(refill_req == 0, "R1 reset refill_req", {31'd0, refill_req}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    lookup(32'h0001_2345, 0, 32'd0, "R1 first miss");
    check(refill_req == 1, "R3 refill_req raised", {31'd0, refill_req}, 32'd1);
    check(refill_vpn == 16'h0001, "R3 refill_vpn", {16'd0, refill_vpn}, 32'h1);
    repeat (4) @(negedge clk);
    check(refill_req == 1, "R3 refill_req held", {31'd0, refill_req}, 32'd1);
    req_valid = 1; req_va = 32'h0001_2345;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check(resp_valid == 0, "R4 ignored while pending", {31'd0, resp_valid}, 32'd0);
    refill(16'h00A0);

    lookup(32'h0001_2345, 1, 32'h00A0_2345, "R5 large hit");
    lookup(32'h0001_F00C, 1, 32'h00A0_F00C, "R5 other sub-page");
    miss_fill(32'h0002_0000, 16'h0102, "R10 other bank miss");

    for (int k = 1; k <= 7; k++) begin
      logic [15:0] v;
      v = 16'(4 * k + 1);
      miss_fill({v, 16'h0000}, v + 16'h0100, "R8 bank fill");
    end
    miss_fill(32'h0021_0000, 16'h0121, "R8 evict oldest");
    lookup(32'h0001_F00C, 1, 32'h00A0_F00C, "R6 evicted sub-page in small store");
    miss_fill(32'h0001_2345, 16'h00B0, "R6 other sub-page misses");
    lookup(32'h0001_F00C, 1, 32'h00A0_F00C, "R7 small wins on double hit");
    lookup(32'h0001_2345, 1, 32'h00B0_2345, "R2 large refreshed");
    lookup(32'h0005_0ABC, 1, 32'h0105_0ABC, "R6 small bank 0");
    lookup(32'h0009_0000, 1, 32'h0109_0000, "R8 reference");
    miss_fill(32'h0025_0000, 16'h0125, "R8 victim lowest clear");
    lookup(32'h0009_1000, 1, 32'h0109_1000, "R8 referenced entry kept");
    lookup(32'h0002_0ABC, 1, 32'h0102_0ABC, "R10 other bank intact");
    lookup(32'h000D_1000, 0, 32'd0, "R8 victim replaced");
    check(refill_req == 1, "R9 pending before flush", {31'd0, refill_req}, 32'd1);

    flush = 1;
    @(negedge clk);
    flush = 0;
    check(refill_req == 0, "R9 flush cancels refill", {31'd0, refill_req}, 32'd0);
    lookup(32'h0001_F00C, 0, 32'd0, "R1 flush empties small");
    flush = 1;
    @(negedge clk);
    flush = 0;
    lookup(32'h0021_0000, 0, 32'd0, "R1 flush empties large");
    flush = 1; req_valid = 1; req_va = 32'h0021_0000;
    @(negedge clk);
    flush = 0; req_valid = 0;
    @(negedge clk);
    check(resp_valid == 0, "R9 flush beats request", {31'd0, resp_valid}, 32'd0);
    check(refill_req == 0, "R9 no refill after flush", {31'd0, refill_req}, 32'd0);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule